// File: doc/BRIEF.md
# Time-Slotted Weighted Port Arbiter

This block hands a shared secondary bus to one of several requesting ports according to a fixed schedule. Time is cut into a repeating cycle of 128 phases. A table holds, for every phase, the number of the port that owns it. An external phase-tick pulse moves the schedule on by one phase. The grant goes to the owner of the current phase, but only when that owner is requesting. A port that owns several phases gets a proportionally larger share of the bus.

Software edits a shadow copy of the table one 32-bit word at a time. It then commits the whole shadow copy to the active table with a single strobe. Until that commit happens, a pending flag reports that the two copies differ. The arbiter runs only when its enable is set and its 3-bit mechanism select holds the timed-schedule code. In normal mode a granted master keeps the bus until its transfer ends. In aggressive mode a phase tick forces the current master off the bus, so the schedule never slips.

Top module: `slot_arbiter`

## Requirements
- R1: After reset, grant, forceOff, pending and phase are all zero, and both tables hold zeros, so every phase is owned by port 0.
- R2: The arbiter is active only while arbEnable is 1 and mechSel equals 3'b100. When it is inactive, grant is zero one cycle later and phase is held at 0.
- R3: While the arbiter is active, each clock edge with phaseTick high moves phase up by one. From 127 it wraps to 0.
- R4: The owner of phase p is bits [4*(p%8)+3 : 4*(p%8)] of table word p/8. A write with cfgWrEn high stores cfgWrData into shadow word cfgWrAddr.
- R5: Shadow writes do not change the grant until a commit. At the commit edge, all 16 shadow words are copied into the active table.
- R6: pending becomes 1 after any shadow write and 0 after a commit made without a write. If a write and a commit fall on the same edge, the commit copies the shadow as it was before that write, and pending stays 1.
- R7: When no transfer is being held, grant is registered from the current phase's owner. It is the one-hot bit of that owner if req of that owner is high, and zero otherwise.
- R8: An entry that names a port number of NUM_PORTS or above gives no grant during its phase.
- R9: In normal mode (aggressive low), a non-zero grant is held unchanged while busBusy is high, even across phase ticks.
- R10: In aggressive mode, a phase tick while a grant is held and busBusy is high clears grant and pulses forceOff for one cycle. On the following edge, arbitration is redone for the new phase.
- R11: grant never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | NUM_PORTS | Per-port bus request |
| busBusy | input | 1 | Granted master's transfer is in progress |
| phaseTick | input | 1 | One-cycle pulse that advances the schedule |
| arbEnable | input | 1 | Level-1 enable of timed arbitration |
| mechSel | input | 3 | Mechanism select; 3'b100 picks the timed schedule |
| aggressive | input | 1 | Level-2 enable: preempt on phase tick |
| cfgWrEn | input | 1 | Shadow table word write strobe |
| cfgWrAddr | input | 4 | Shadow table word index |
| cfgWrData | input | 32 | Eight 4-bit entries, lowest phase in low bits |
| commit | input | 1 | Copy shadow table into active table |
| grant | output | NUM_PORTS | One-hot bus grant |
| forceOff | output | 1 | Preemption pulse to the current master |
| pending | output | 1 | Shadow table differs from committed copy |
| phase | output | 7 | Current phase index |

## Verification
The schedule is first programmed so that phase p belongs to port p%8. It is then driven with all ports requesting, with the phase owner alone withdrawn, and with only a non-owner requesting. This separates true table lookup from simple fixed-priority or round-robin behaviour. Runs with busBusy high across ticks show the difference between holding in normal mode and preempting in aggressive mode. A full wrap through an out-of-range entry, and shadow edits checked before and after commit (including a write and a commit on the same edge), show which copy of the table drives the grant.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam logic [2:0] MECH_TIMED = 3'b100;

  typedef struct packed {
    logic wrShadow;
    logic loadActive;
    logic advPhase;
    logic clrPhase;
  } dpStrobe_t;
endpackage

// File: rtl/slot_arb_dp.sv
module slot_arb_dp
  import slot_arb_pkg::*;
#(
  parameter int PHASES  = 128,
  parameter int ENTRY_W = 4,
  parameter int WORD_W  = 32,
  parameter int PHASE_W = $clog2(PHASES),
  parameter int PER_WORD = WORD_W / ENTRY_W,
  parameter int WORDS   = PHASES / PER_WORD,
  parameter int ADDR_W  = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strb,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [WORD_W-1:0]  wrData,
  output logic [PHASE_W-1:0] phase,
  output logic [ENTRY_W-1:0] owner
);
  localparam int SLOT_W = $clog2(PER_WORD);

  logic [WORD_W-1:0] shadowTbl [WORDS];
  logic [WORD_W-1:0] activeTbl [WORDS];
  logic [WORD_W-1:0] curWord;
  logic [ADDR_W-1:0] wordSel;
  logic [SLOT_W-1:0] slotSel;

  // Commit reads the shadow before any same-edge write lands.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) begin
        shadowTbl[i] <= '0;
        activeTbl[i] <= '0;
      end
    end else begin
      if (strb.loadActive) begin
        for (int i = 0; i < WORDS; i++) activeTbl[i] <= shadowTbl[i];
      end
      if (strb.wrShadow) shadowTbl[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrPhase) phase <= '0;
    else if (strb.advPhase)
      phase <= (phase == PHASE_W'(PHASES - 1)) ? '0 : phase + 1'b1;
  end

  assign wordSel = phase[PHASE_W-1:SLOT_W];
  assign slotSel = phase[SLOT_W-1:0];
  assign curWord = activeTbl[wordSel];
  assign owner   = curWord[int'(slotSel)*ENTRY_W +: ENTRY_W];

  // R3: wrap from the last phase back to zero
  p_phase_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advPhase && !strb.clrPhase && phase == PHASE_W'(PHASES - 1)) |=> (phase == '0));

  // R3: an ordinary tick adds exactly one
  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advPhase && !strb.clrPhase && phase != PHASE_W'(PHASES - 1))
      |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/slot_arb_ctrl.sv
module slot_arb_ctrl
  import slot_arb_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int ENTRY_W   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] req,
  input  logic                 busBusy,
  input  logic                 phaseTick,
  input  logic                 arbEnable,
  input  logic [2:0]           mechSel,
  input  logic                 aggressive,
  input  logic                 cfgWrEn,
  input  logic                 commit,
  input  logic [ENTRY_W-1:0]   owner,
  output dpStrobe_t            strb,
  output logic [NUM_PORTS-1:0] grant,
  output logic                 forceOff,
  output logic                 pending
);
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic                 modeOn;
  logic                 ownerOk;
  logic                 ownerReq;
  logic                 holding;
  logic                 preemptNow;
  logic [NUM_PORTS-1:0] cand;
  logic [NUM_PORTS-1:0] grantNxt;
  logic [PORT_W-1:0]    ownerIdx;

  assign modeOn = arbEnable && (mechSel == MECH_TIMED);

  always_comb begin
    strb            = '0;
    strb.wrShadow   = cfgWrEn;
    strb.loadActive = commit;
    strb.advPhase   = modeOn && phaseTick;
    strb.clrPhase   = !modeOn;
  end

  assign ownerIdx = PORT_W'(owner);
  assign ownerOk  = int'(owner) < NUM_PORTS;
  assign ownerReq = ownerOk && req[ownerIdx];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_cand
    assign cand[g] = ownerReq && (int'(owner) == g);
  end

  assign holding    = (|grant) && busBusy;
  assign preemptNow = modeOn && aggressive && phaseTick && holding;

  always_comb begin
    if (!modeOn || preemptNow) grantNxt = '0;
    else if (holding)          grantNxt = grant;
    else                       grantNxt = cand;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grant    <= '0;
      forceOff <= 1'b0;
      pending  <= 1'b0;
    end else begin
      grant    <= grantNxt;
      forceOff <= preemptNow;
      if (cfgWrEn)     pending <= 1'b1;
      else if (commit) pending <= 1'b0;
    end
  end

  // R11: at most one grant
  p_grant_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R2: inactive arbiter grants nobody
  p_idle_nogrant_r2: assert property (@(posedge clk) disable iff (!rstN)
    !modeOn |=> (grant == '0));

  // R9: normal-mode hold while the transfer runs
  p_hold_normal_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeOn && !aggressive && (|grant) && busBusy) |=> $stable(grant));

  // R10: aggressive preemption drops the grant and pulses forceOff
  p_preempt_r10: assert property (@(posedge clk) disable iff (!rstN)
    (modeOn && aggressive && phaseTick && (|grant) && busBusy)
      |=> (grant == '0 && forceOff));

  // R6: any write leaves the table marked as pending
  p_write_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> pending);

  // R6: a commit without a write clears the pending flag
  p_commit_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (commit && !cfgWrEn) |=> !pending);
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PHASES    = 128,
  parameter int ENTRY_W   = 4,
  parameter int WORD_W    = 32,
  parameter int PHASE_W   = $clog2(PHASES),
  parameter int ADDR_W    = $clog2(PHASES / (WORD_W / ENTRY_W))
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] req,
  input  logic                 busBusy,
  input  logic                 phaseTick,
  input  logic                 arbEnable,
  input  logic [2:0]           mechSel,
  input  logic                 aggressive,
  input  logic                 cfgWrEn,
  input  logic [ADDR_W-1:0]    cfgWrAddr,
  input  logic [WORD_W-1:0]    cfgWrData,
  input  logic                 commit,
  output logic [NUM_PORTS-1:0] grant,
  output logic                 forceOff,
  output logic                 pending,
  output logic [PHASE_W-1:0]   phase
);
  dpStrobe_t          strb;
  logic [ENTRY_W-1:0] owner;

  slot_arb_ctrl #(
    .NUM_PORTS(NUM_PORTS),
    .ENTRY_W  (ENTRY_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .req       (req),
    .busBusy   (busBusy),
    .phaseTick (phaseTick),
    .arbEnable (arbEnable),
    .mechSel   (mechSel),
    .aggressive(aggressive),
    .cfgWrEn   (cfgWrEn),
    .commit    (commit),
    .owner     (owner),
    .strb      (strb),
    .grant     (grant),
    .forceOff  (forceOff),
    .pending   (pending)
  );

  slot_arb_dp #(
    .PHASES (PHASES),
    .ENTRY_W(ENTRY_W),
    .WORD_W (WORD_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrAddr(cfgWrAddr),
    .wrData(cfgWrData),
    .phase (phase),
    .owner (owner)
  );
endmodule

// File: tb/slot_arbiter_test.sv
module slot_arbiter_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] req = '0;
  logic       busBusy = 1'b0, phaseTick = 1'b0, arbEnable = 1'b0;
  logic [2:0] mechSel = 3'b000;
  logic       aggressive = 1'b0, cfgWrEn = 1'b0, commit = 1'b0;
  logic [3:0] cfgWrAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [7:0] grant;
  logic       forceOff, pending;
  logic [6:0] phase;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  slot_arbiter uut (
    .clk(clk), .rstN(rstN), .req(req), .busBusy(busBusy), .phaseTick(phaseTick),
    .arbEnable(arbEnable), .mechSel(mechSel), .aggressive(aggressive),
    .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData), .commit(commit),
    .grant(grant), .forceOff(forceOff), .pending(pending), .phase(phase)
  );

  // fields: tick, busy, req[8], expected grant[8], expected phase[7]
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'hFF, 8'h01, 7'd0},
    {1'b1, 1'b0, 8'hFF, 8'h01, 7'd1},
    {1'b0, 1'b0, 8'hFF, 8'h02, 7'd1},
    {1'b0, 1'b0, 8'hFD, 8'h00, 7'd1},
    {1'b1, 1'b0, 8'hFF, 8'h02, 7'd2},
    {1'b0, 1'b0, 8'hFF, 8'h04, 7'd2},
    {1'b1, 1'b1, 8'hFF, 8'h04, 7'd3},
    {1'b0, 1'b1, 8'hFF, 8'h04, 7'd3},
    {1'b0, 1'b0, 8'hFF, 8'h08, 7'd3},
    {1'b0, 1'b0, 8'h00, 8'h00, 7'd3},
    {1'b1, 1'b0, 8'h00, 8'h00, 7'd4},
    {1'b0, 1'b0, 8'h10, 8'h10, 7'd4},
    {1'b1, 1'b0, 8'hFF, 8'h10, 7'd5},
    {1'b0, 1'b0, 8'hFF, 8'h20, 7'd5}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cfgWrEn = 1'b1; cfgWrAddr = a; cfgWrData = d;
    step();
    cfgWrEn = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    // R1: reset state
    chk("R1 grant", 32'(grant), 0);
    chk("R1 pending", 32'(pending), 0);
    chk("R1 phase", 32'(phase), 0);
    chk("R1 forceOff", 32'(forceOff), 0);
    rstN = 1'b1;
    step();

    // R4: phase p owned by port p%8; phase 127 names port 9
    for (int w = 0; w < 16; w++) wr(4'(w), (w == 15) ? 32'h96543210 : 32'h76543210);
    chk("R6 pending after writes", 32'(pending), 1);
    commit = 1'b1; step(); commit = 1'b0;
    chk("R6 pending after commit", 32'(pending), 0);
    arbEnable = 1'b1; mechSel = 3'b100;
    step();

    // R7 R9 R3: vector walk
    for (int i = 0; i < NV; i++) begin
      phaseTick = VEC[i][24]; busBusy = VEC[i][23]; req = VEC[i][22:15];
      step();
      chk($sformatf("R7/R9 vec %0d grant", i), 32'(grant), 32'(VEC[i][14:7]));
      chk($sformatf("R3 vec %0d phase", i), 32'(phase), 32'(VEC[i][6:0]));
    end
    phaseTick = 1'b0; busBusy = 1'b0;

    // R10: aggressive preemption at phase 5 with port 5 granted
    aggressive = 1'b1; busBusy = 1'b1; phaseTick = 1'b1;
    step();
    phaseTick = 1'b0; busBusy = 1'b0;
    chk("R10 grant dropped", 32'(grant), 0);
    chk("R10 forceOff", 32'(forceOff), 1);
    chk("R10 phase", 32'(phase), 6);
    step();
    chk("R10 regrant", 32'(grant), 32'h40);
    chk("R10 forceOff pulse", 32'(forceOff), 0);
    aggressive = 1'b0;

    // R3 R8: run to phase 127, owned by out-of-range port 9
    req = '0; phaseTick = 1'b1;
    for (int k = 0; k < 121; k++) step();
    phaseTick = 1'b0; req = 8'hFF;
    step();
    chk("R3 reach 127", 32'(phase), 127);
    chk("R8 no grant for port 9", 32'(grant), 0);
    phaseTick = 1'b1; step(); phaseTick = 1'b0;
    chk("R3 wrap", 32'(phase), 0);
    step();
    chk("R3 phase0 grant", 32'(grant), 32'h01);

    // R5: shadow write has no effect until commit
    wr(4'd0, 32'h00000003);
    chk("R6 pending set", 32'(pending), 1);
    step();
    chk("R5 grant before commit", 32'(grant), 32'h01);
    commit = 1'b1; step(); commit = 1'b0;
    chk("R6 pending cleared", 32'(pending), 0);
    step();
    chk("R5 grant after commit", 32'(grant), 32'h08);

    // R6: write and commit on the same edge
    cfgWrEn = 1'b1; cfgWrAddr = 4'd0; cfgWrData = 32'h00000005; commit = 1'b1;
    step();
    cfgWrEn = 1'b0; commit = 1'b0;
    chk("R6 pending kept", 32'(pending), 1);
    step();
    chk("R6 commit took old shadow", 32'(grant), 32'h08);
    commit = 1'b1; step(); commit = 1'b0;
    step();
    chk("R6 second commit grant", 32'(grant), 32'h20);
    chk("R6 second commit pending", 32'(pending), 0);

    // R2: mode select gating
    phaseTick = 1'b1; step();
    mechSel = 3'b110; step(); phaseTick = 1'b0;
    chk("R2 wrong mech grant", 32'(grant), 0);
    chk("R2 wrong mech phase", 32'(phase), 0);
    mechSel = 3'b100; arbEnable = 1'b0; step();
    chk("R2 disabled grant", 32'(grant), 0);

    // R1: reset in mid-run clears tables
    arbEnable = 1'b1; wr(4'd1, 32'h11111111);
    rstN = 1'b0; step();
    chk("R1 mid reset grant", 32'(grant), 0);
    chk("R1 mid reset pending", 32'(pending), 0);
    chk("R1 mid reset phase", 32'(phase), 0);
    rstN = 1'b1; req = 8'hFF; step();
    chk("R1 zero table owner", 32'(grant), 32'h01);
    phaseTick = 1'b1; step(); phaseTick = 1'b0;
    step();
    chk("R1 zero table phase1", 32'(grant), 32'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule